// File: doc/BRIEF.md
# USB OUT Endpoint Receive Handler

This block takes host-to-device data packets for a device with up to sixteen OUT endpoints and stores them in a single shared receive FIFO. The FIFO holds 66 bytes: a full 64-byte payload plus the two CRC16 bytes, which are kept with the payload. Firmware arms an endpoint by writing its number together with an enable flag. The block then accepts one packet for that endpoint and drops the endpoint's enable again on its own. Firmware reads the bytes out one per pop, looks up which endpoint sent them, and clears a completion flag to make the FIFO available for the next packet.

On the protocol side, a token strobe carries the endpoint number of an OUT token. A byte stream follows, then an end-of-packet strobe that comes with a CRC-valid flag. One cycle after end-of-packet the block answers with ACK, NAK or STALL, or gives no answer at all when the packet is corrupt or too long. Serialisation, bit stuffing and CRC computation are handled elsewhere.

Top module: `usb_out_rx`

## Requirements
- R1: Reset leaves the FIFO empty (`fifo_level` 0), `done_pend` 0, `stat_ep` 0, `hs_valid` 0, and every endpoint disabled and unstalled.
- R2: When a token names an endpoint that is enabled and not stalled, the FIFO is empty and `done_pend` is 0, every received byte is stored. A good-CRC end-of-packet then gives `hs_valid` high with `hs_code` 2'b00 (ACK) in the cycle after the end-of-packet strobe.
- R3: An accepted packet sets `done_pend`, loads `stat_ep` with its endpoint, and clears that endpoint's enable, so the next packet to it gets NAK. `stat_ep` changes at no other time.
- R4: `fifo_level` counts every stored byte, CRC bytes included. A zero-length packet (2 bytes) and a full packet (66 bytes) are both accepted.
- R5: `rd_data` shows the oldest stored byte. A pop advances to the next byte and lowers `fifo_level` by one. A pop on an empty FIFO has no effect.
- R6: A packet to an endpoint that is not enabled gets `hs_code` 2'b01 (NAK), and none of its bytes is stored.
- R7: While `done_pend` is set, every packet gets NAK even if its endpoint is enabled. A pulse on `ev_clr` clears `done_pend`.
- R8: While the FIFO still holds unread bytes, every packet gets NAK. The endpoint stays enabled and its packet is accepted once the FIFO has been drained.
- R9: A control write with `ctl_stall` 1 marks the endpoint stalled, and packets to it get `hs_code` 2'b10 (STALL). A write with `ctl_stall` 0 removes the stall. STALL takes precedence over the NAK conditions.
- R10: A control write with both `ctl_en` and `ctl_stall` set stalls the endpoint and leaves its enable cleared.
- R11: A bad-CRC packet, or a packet longer than 66 bytes, gets no handshake. The FIFO returns to empty, and `done_pend` and `stat_ep` keep their values.
- R12: A pulse on `ctl_flush` empties the FIFO and clears the enable of every endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe for one endpoint |
| ctl_ep | input | 4 | Endpoint addressed by the control write |
| ctl_en | input | 1 | Enable value written |
| ctl_stall | input | 1 | Stall value written |
| ctl_flush | input | 1 | Empty the FIFO and disable all endpoints |
| rd_pop | input | 1 | Consume the head byte |
| rd_data | output | 8 | Head byte of the FIFO |
| fifo_level | output | 7 | Number of readable bytes |
| ev_clr | input | 1 | Clear the completion flag |
| done_pend | output | 1 | A packet has been accepted and not yet acknowledged by firmware |
| stat_ep | output | 4 | Endpoint of the last accepted packet |
| tok_valid | input | 1 | OUT token strobe |
| tok_ep | input | 4 | Endpoint named by the token |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_crc_ok | input | 1 | CRC was correct, valid with `rx_eop` |
| hs_valid | output | 1 | Handshake to send, one cycle |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |

## Verification
The hardest case to reach is an over-long packet that fills the FIFO to exactly 66 bytes and then arrives with one more byte. The 67th byte must trigger a rollback that leaves no trace: no handshake, `fifo_level` back to 0, and `done_pend` and `stat_ep` unchanged from the earlier accepted packet. The bench reaches this state by first sending a full 66-byte packet, draining it and re-arming, and then streaming 67 bytes to a newly enabled endpoint. A bad-CRC packet follows on the same endpoint, and then a good one, to show that the endpoint's enable survived both rejected packets.

// File: rtl/usb_out_pkg.sv
package usb_out_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RECV = 2'b01,
    ST_SKIP = 2'b10
  } rx_st_t;
endpackage

// File: rtl/out_ep_table.sv
module out_ep_table #(
  parameter int NUM_EP = 16,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [EPW-1:0]    ctl_ep,
  input  logic              ctl_en,
  input  logic              ctl_stall,
  input  logic              flush,
  input  logic              auto_clr,
  input  logic [EPW-1:0]    auto_ep,
  output logic [NUM_EP-1:0] en_vec,
  output logic [NUM_EP-1:0] stall_vec
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit_wr, hit_clr;
    assign hit_wr  = ctl_wr && (ctl_ep == EPW'(i));
    assign hit_clr = auto_clr && (auto_ep == EPW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_vec[i]    <= 1'b0;
        stall_vec[i] <= 1'b0;
      end else begin
        if (hit_wr) begin
          stall_vec[i] <= ctl_stall;
          en_vec[i]    <= ctl_en && !ctl_stall;
        end
        if (hit_clr || flush) en_vec[i] <= 1'b0;
      end
    end

    assert_stall_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (hit_wr && ctl_stall) |=> (stall_vec[i] && !en_vec[i]));
  end

  assert_flush_disables_R12: assert property (@(posedge clk) disable iff (rst)
    flush |=> (en_vec == '0));
endmodule

// File: rtl/out_rx_fifo.sv
module out_rx_fifo #(
  parameter int DEPTH = 66,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          restart,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rollback,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] wr_cnt, commit_cnt, rd_ptr;

  assign level   = commit_cnt - rd_ptr;
  assign empty   = (level == '0);
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_cnt < LW'(DEPTH))) mem[wr_cnt[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_cnt     <= '0;
      commit_cnt <= '0;
      rd_ptr     <= '0;
      ovf        <= 1'b0;
    end else if (restart) begin
      wr_cnt     <= '0;
      commit_cnt <= '0;
      rd_ptr     <= '0;
      ovf        <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_cnt == LW'(DEPTH)) ovf <= 1'b1;
        else                      wr_cnt <= wr_cnt + 1'b1;
      end
      if (commit) commit_cnt <= wr_cnt;
      if (rollback) begin
        wr_cnt <= '0;
        ovf    <= 1'b0;
      end
      if (rd_pop && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  assert_rollback_empty_R11: assert property (@(posedge clk) disable iff (rst)
    rollback |=> empty);
  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && empty && !commit && !restart) |=> (level == '0));
endmodule

// File: rtl/usb_out_rx.sv
module usb_out_rx
  import usb_out_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int DEPTH  = 66,
  parameter int DW     = 8,
  localparam int EPW = $clog2(NUM_EP),
  localparam int LW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctl_wr,
  input  logic [EPW-1:0] ctl_ep,
  input  logic           ctl_en,
  input  logic           ctl_stall,
  input  logic           ctl_flush,
  input  logic           rd_pop,
  output logic [DW-1:0]  rd_data,
  output logic [LW-1:0]  fifo_level,
  input  logic           ev_clr,
  output logic           done_pend,
  output logic [EPW-1:0] stat_ep,
  input  logic           tok_valid,
  input  logic [EPW-1:0] tok_ep,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_eop,
  input  logic           rx_crc_ok,
  output logic           hs_valid,
  output logic [1:0]     hs_code
);
  rx_st_t            state;
  hs_t               skip_code;
  logic [EPW-1:0]    cur_ep;
  logic [NUM_EP-1:0] en_vec, stall_vec;
  logic              f_empty, f_ovf;
  logic              tok_stall, tok_ok, live;
  logic              f_restart, f_wr, f_commit, f_rollback;

  assign live      = !ctl_flush && !tok_valid;
  assign tok_stall = stall_vec[tok_ep];
  assign tok_ok    = en_vec[tok_ep] && !done_pend && f_empty;

  assign f_restart  = !ctl_flush && tok_valid && !tok_stall && tok_ok;
  assign f_wr       = live && (state == ST_RECV) && rx_valid;
  assign f_commit   = live && (state == ST_RECV) && rx_eop && rx_crc_ok && !f_ovf;
  assign f_rollback = live && (state == ST_RECV) && rx_eop && !(rx_crc_ok && !f_ovf);

  out_ep_table #(.NUM_EP(NUM_EP)) u_table (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_ep   (ctl_ep),
    .ctl_en   (ctl_en),
    .ctl_stall(ctl_stall),
    .flush    (ctl_flush),
    .auto_clr (f_commit),
    .auto_ep  (cur_ep),
    .en_vec   (en_vec),
    .stall_vec(stall_vec)
  );

  out_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (ctl_flush),
    .restart (f_restart),
    .wr_en   (f_wr),
    .wr_data (rx_data),
    .commit  (f_commit),
    .rollback(f_rollback),
    .rd_pop  (rd_pop),
    .rd_data (rd_data),
    .level   (fifo_level),
    .empty   (f_empty),
    .ovf     (f_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      skip_code <= HS_NAK;
      cur_ep    <= '0;
      done_pend <= 1'b0;
      stat_ep   <= '0;
      hs_valid  <= 1'b0;
      hs_code   <= HS_ACK;
    end else begin
      hs_valid <= 1'b0;
      if (ev_clr) done_pend <= 1'b0;
      if (ctl_flush) begin
        state <= ST_IDLE;
      end else if (tok_valid) begin
        cur_ep <= tok_ep;
        if (tok_stall) begin
          state     <= ST_SKIP;
          skip_code <= HS_STALL;
        end else if (tok_ok) begin
          state <= ST_RECV;
        end else begin
          state     <= ST_SKIP;
          skip_code <= HS_NAK;
        end
      end else if (rx_eop) begin
        if (state == ST_RECV && f_commit) begin
          hs_valid  <= 1'b1;
          hs_code   <= HS_ACK;
          done_pend <= 1'b1;
          stat_ep   <= cur_ep;
        end else if (state == ST_SKIP && rx_crc_ok) begin
          hs_valid <= 1'b1;
          hs_code  <= skip_code;
        end
        state <= ST_IDLE;
      end
    end
  end

  assert_ack_sets_done_R3: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == HS_ACK) |-> done_pend);
  assert_stat_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(hs_valid && hs_code == HS_ACK) |-> $stable(stat_ep));
  assert_done_from_ack_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(done_pend) |-> (hs_valid && hs_code == HS_ACK));
  assert_clr_done_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_clr && !f_commit) |=> !done_pend);
endmodule

// File: tb/usb_out_rx_bench.sv
`timescale 1ns/1ps
module usb_out_rx_bench;
  localparam int NONE = 3;
  localparam int ACK = 0, NAK = 1, STL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_en = 0, ctl_stall = 0, ctl_flush = 0;
  logic [3:0] ctl_ep = 0;
  logic rd_pop = 0, ev_clr = 0;
  logic [7:0] rd_data;
  logic [6:0] fifo_level;
  logic done_pend;
  logic [3:0] stat_ep;
  logic tok_valid = 0;
  logic [3:0] tok_ep = 0;
  logic rx_valid = 0, rx_eop = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = 0;
  logic hs_valid;
  logic [1:0] hs_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_out_rx u_usb_out_rx (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_ep(ctl_ep), .ctl_en(ctl_en), .ctl_stall(ctl_stall),
    .ctl_flush(ctl_flush), .rd_pop(rd_pop), .rd_data(rd_data),
    .fifo_level(fifo_level), .ev_clr(ev_clr), .done_pend(done_pend),
    .stat_ep(stat_ep), .tok_valid(tok_valid), .tok_ep(tok_ep),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
    .rx_crc_ok(rx_crc_ok), .hs_valid(hs_valid), .hs_code(hs_code)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic ctl(input int ep, input bit en, input bit st);
    @(negedge clk);
    ctl_wr = 1; ctl_ep = 4'(ep); ctl_en = en; ctl_stall = st;
    @(negedge clk);
    ctl_wr = 0; ctl_en = 0; ctl_stall = 0;
  endtask

  task automatic clear_done();
    @(negedge clk); ev_clr = 1;
    @(negedge clk); ev_clr = 0;
  endtask

  task automatic flush();
    @(negedge clk); ctl_flush = 1;
    @(negedge clk); ctl_flush = 0;
  endtask

  task automatic send(input int ep, input int n, input bit crc, input int base, output int res);
    @(negedge clk);
    tok_valid = 1; tok_ep = 4'(ep);
    @(negedge clk);
    tok_valid = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = 8'(base + i);
      @(negedge clk);
    end
    rx_valid = 0;
    rx_eop = 1; rx_crc_ok = crc;
    @(posedge clk); #1;
    res = hs_valid ? int'(hs_code) : NONE;
    @(negedge clk);
    rx_eop = 0; rx_crc_ok = 0;
  endtask

  task automatic pop(output int b);
    @(negedge clk);
    b = int'(rd_data);
    rd_pop = 1;
    @(negedge clk);
    rd_pop = 0;
  endtask

  task automatic drain(input string req, input int n, input int base);
    int b;
    for (int i = 0; i < n; i++) begin
      pop(b);
      if (base >= 0) check(req, b, (base + i) & 255);
    end
    check(req, int'(fifo_level), 0);
  endtask

  task automatic t_reset();
    int r;
    check("R1 level", int'(fifo_level), 0);
    check("R1 done", int'(done_pend), 0);
    check("R1 stat", int'(stat_ep), 0);
    check("R1 hs_valid", int'(hs_valid), 0);
    send(0, 4, 1, 8'h40, r);
    check("R1/R6 disabled ep NAK", r, NAK);
    check("R6 nothing stored", int'(fifo_level), 0);
  endtask

  task automatic t_basic();
    int r, b;
    ctl(3, 1, 0);
    send(3, 4, 1, 8'h10, r);
    check("R2 ack", r, ACK);
    check("R3 done", int'(done_pend), 1);
    check("R3 stat", int'(stat_ep), 3);
    check("R4 level", int'(fifo_level), 4);
    drain("R5 data order", 4, 8'h10);
    pop(b);
    check("R5 pop on empty", int'(fifo_level), 0);
  endtask

  task automatic t_pending();
    int r;
    ctl(3, 1, 0);
    send(3, 3, 1, 8'h20, r);
    check("R7 pending NAK", r, NAK);
    check("R7 nothing stored", int'(fifo_level), 0);
    clear_done();
    check("R7 clear", int'(done_pend), 0);
    send(3, 3, 1, 8'h20, r);
    check("R7 ack after clear", r, ACK);
    drain("R5 drain", 3, 8'h20);
    clear_done();
    send(3, 3, 1, 8'h20, r);
    check("R3 enable auto-cleared", r, NAK);
  endtask

  task automatic t_nonempty();
    int r;
    ctl(5, 1, 0);
    send(5, 2, 1, 8'h30, r);
    check("R2 ack ep5", r, ACK);
    clear_done();
    ctl(5, 1, 0);
    send(5, 2, 1, 8'h50, r);
    check("R8 nonempty NAK", r, NAK);
    check("R8 level kept", int'(fifo_level), 2);
    drain("R8 old data", 2, 8'h30);
    send(5, 2, 1, 8'h50, r);
    check("R8 ack after drain", r, ACK);
    drain("R8 new data", 2, 8'h50);
    clear_done();
  endtask

  task automatic t_sizes();
    int r;
    ctl(1, 1, 0);
    send(1, 2, 1, 8'h60, r);
    check("R4 zero-length ack", r, ACK);
    check("R4 zero-length level", int'(fifo_level), 2);
    drain("R4 drain", 2, 8'h60);
    clear_done();
    ctl(1, 1, 0);
    send(1, 66, 1, 8'h00, r);
    check("R4 full ack", r, ACK);
    check("R4 full level", int'(fifo_level), 66);
    drain("R4 full data", 66, 0);
    clear_done();
  endtask

  task automatic t_errors();
    int r;
    ctl(7, 1, 0);
    send(7, 67, 1, 8'h00, r);
    check("R11 overflow no hs", r, NONE);
    check("R11 overflow level", int'(fifo_level), 0);
    check("R11 overflow done", int'(done_pend), 0);
    check("R11 overflow stat", int'(stat_ep), 1);
    send(7, 5, 0, 8'h70, r);
    check("R11 bad crc no hs", r, NONE);
    check("R11 bad crc level", int'(fifo_level), 0);
    check("R11 bad crc done", int'(done_pend), 0);
    check("R11 bad crc stat", int'(stat_ep), 1);
    send(7, 2, 1, 8'h70, r);
    check("R11 ack after rejects", r, ACK);
    check("R3 stat ep7", int'(stat_ep), 7);
    drain("R5 drain ep7", 2, 8'h70);
    clear_done();
  endtask

  task automatic t_stall();
    int r;
    ctl(2, 0, 1);
    send(2, 2, 1, 8'h80, r);
    check("R9 stall", r, STL);
    check("R9 nothing stored", int'(fifo_level), 0);
    ctl(2, 0, 0);
    send(2, 2, 1, 8'h80, r);
    check("R9 unstall gives NAK", r, NAK);
    ctl(2, 1, 1);
    send(2, 2, 1, 8'h80, r);
    check("R10 stall wins", r, STL);
    ctl(2, 0, 0);
    send(2, 2, 1, 8'h80, r);
    check("R10 enable left clear", r, NAK);
  endtask

  task automatic t_flush();
    int r;
    ctl(4, 1, 0);
    ctl(6, 1, 0);
    send(4, 3, 1, 8'h90, r);
    check("R2 ack ep4", r, ACK);
    clear_done();
    flush();
    check("R12 level", int'(fifo_level), 0);
    send(6, 2, 1, 8'h90, r);
    check("R12 enables cleared", r, NAK);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pending();
    t_nonempty();
    t_sizes();
    t_errors();
    t_stall();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule